// File: doc/BRIEF.md
# Dual-role synchronous serial port

This block is a byte-wide synchronous serial port. It can act as the bus master, which generates the serial clock and the transfer, or as a slave, which follows a clock from outside. One control bit picks the role. The two data pins change direction with the role. Pin A is the output in master mode and the input in slave mode. Pin B is the input in master mode and the output in slave mode. Each pad signal has its own output enable.

Software uses a small register bus with three locations:

- **Control (address 0):** role bit, select-pin reuse, and clock divider.
- **Status (address 1):** completion flag and fault flag.
- **Data (address 2):** a write loads the transmit byte, and a read returns the received byte.

In master mode, writing the data register starts a transfer. In slave mode, the port shifts only while the active-low select input is held low. If the select input goes low while the port is a master and the select pin has not been reused, the port reports a mode fault and releases the bus. A master can instead use the select pin as a general-purpose output bit.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register reads 0 (slave role), the status register reads 0, and every pad output enable (`sck_oe`, `pa_oe`, `pb_oe`, `sel_oe`) is low.
- R2: With control bit 0 = 1 (master), `sck_oe` and `pa_oe` are high and `pb_oe` is low. With bit 0 = 0, `sck_oe` and `pa_oe` are low.
- R3: A master transfer starts on a write to address 2. It sends the 8-bit byte MSB first on `pa_o`, changing on falling clock edges. It captures 8 bits from `pb_i` on rising edges, MSB first. A read of address 2 then returns the captured byte.
- R4: The master serial clock idles low. Each phase lasts N+1 system clocks, where N is control bits [7:4]. Status bit 0 becomes 1 exactly 16×(N+1) clocks after the data write edge and not earlier.
- R5: Status bit 0 (done) is set after the eighth bit. It stays set until address 2 is read, and that read clears it.
- R6: A slave with `sel_n_i` low drives `pb_oe` high. It sends the byte last written to address 2 MSB first on `pb_o`. It captures `pa_i` on rising `sck_i` edges. `sck_i` and `sel_n_i` each pass through a two-flop synchronizer.
- R7: A slave with `sel_n_i` high keeps `pb_oe` low and ignores `sck_i` edges. Done stays 0 and the received byte is unchanged.
- R8: In master mode with select reuse off (control bit 1 = 0), a low `sel_n_i` causes a mode fault. The fault clears control bit 0, sets status bit 1, and drops `sck_oe` and `pa_oe`.
- R9: Status bit 1 stays set after `sel_n_i` returns high. Only a write to address 1 clears it.
- R10: In master mode with control bit 1 = 1, `sel_oe` is high and `sel_o` follows control bit 2. In that case a low `sel_n_i` causes no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (the data read clears done) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sck_i | input | 1 | Serial clock pad input |
| sck_o | output | 1 | Serial clock pad output |
| sck_oe | output | 1 | Serial clock output enable |
| pa_i | input | 1 | Data pin A input (slave receive) |
| pa_o | output | 1 | Data pin A output (master send) |
| pa_oe | output | 1 | Data pin A output enable |
| pb_i | input | 1 | Data pin B input (master receive) |
| pb_o | output | 1 | Data pin B output (slave send) |
| pb_oe | output | 1 | Data pin B output enable |
| sel_n_i | input | 1 | Active-low select pad input |
| sel_o | output | 1 | Select pad output (general-purpose bit) |
| sel_oe | output | 1 | Select pad output enable |

## Verification
The assertions check on every cycle that the pad enables match the role and that the master and slave drivers never overlap. They also check that a fault always leaves the port a slave and that the done and fault flags hold until their own clearing access. Only the bench's scenarios can show the bit order on both data pins, the received bytes, and the exact clock count to done for two divider values. The same holds for slave deafness without a select and for the select pin used as an output bit in place of a fault trigger.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW   = 8,
  parameter int DIVW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       pa_i,
  output logic       pa_o,
  output logic       pa_oe,
  input  logic       pb_i,
  output logic       pb_o,
  output logic       pb_oe,
  input  logic       sel_n_i,
  output logic       sel_o,
  output logic       sel_oe
);
  localparam int BW = (DW > 2) ? $clog2(DW) : 1;

  logic            master, gpio_en, gpio_val, busy, done, fault, sck_q, samp;
  logic [DIVW-1:0] div_n, div_cnt;
  logic [DW-1:0]   shreg, rx_q;
  logic [BW-1:0]   bits;
  logic [2:0]      sck_s;
  logic [1:0]      sel_s;

  wire sel_act   = ~sel_s[1];
  wire tick      = busy && (div_cnt == div_n);
  wire sl_en     = !master && sel_act;
  wire rise      = (master && tick && !sck_q) || (sl_en && sck_s[1] && !sck_s[2]);
  wire fall      = (master && tick &&  sck_q) || (sl_en && !sck_s[1] && sck_s[2]);
  wire in_bit    = master ? pb_i : pa_i;
  wire fault_hit = master && !gpio_en && sel_act;
  wire wr_ctrl   = bus_wr && bus_addr == 2'd0;
  wire wr_stat   = bus_wr && bus_addr == 2'd1;
  wire wr_data   = bus_wr && bus_addr == 2'd2;
  wire rd_data   = bus_rd && bus_addr == 2'd2;
  wire [DW-1:0] sh_next = {shreg[DW-2:0], samp};

  assign sck_o  = sck_q;
  assign sck_oe = master;
  assign pa_o   = shreg[DW-1];
  assign pa_oe  = master;
  assign pb_o   = shreg[DW-1];
  assign pb_oe  = sl_en;
  assign sel_o  = gpio_val;
  assign sel_oe = master && gpio_en;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = 8'({div_n, 1'b0, gpio_val, gpio_en, master});
      2'd1:    bus_rdata = {6'd0, fault, done};
      2'd2:    bus_rdata = 8'(rx_q);
      default: bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {master, gpio_en, gpio_val, busy, done, fault, sck_q, samp} <= '0;
      div_n <= '0; div_cnt <= '0; shreg <= '0; rx_q <= '0; bits <= '0;
      sck_s <= '0; sel_s <= 2'b11;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      sel_s <= {sel_s[0], sel_n_i};
      if (wr_ctrl) {div_n, gpio_val, gpio_en, master} <= {bus_wdata[7:4], bus_wdata[2:0]};
      if (wr_stat) fault <= 1'b0;
      if (rd_data) done <= 1'b0;
      if (wr_data) begin
        shreg <= bus_wdata[DW-1:0];
        bits  <= '0;
        if (master) begin
          busy <= 1'b1; div_cnt <= '0; sck_q <= 1'b0;
        end
      end else begin
        if (busy) begin
          if (tick) begin
            div_cnt <= '0;
            sck_q   <= ~sck_q;
          end else div_cnt <= div_cnt + 1'b1;
        end
        if (rise) samp <= in_bit;
        if (fall) begin
          shreg <= sh_next;
          if (bits == BW'(DW-1)) begin
            bits <= '0; done <= 1'b1; rx_q <= sh_next; busy <= 1'b0;
          end else bits <= bits + 1'b1;
        end
        if (!master && !sel_act) bits <= '0;
      end
      if (fault_hit) begin
        master <= 1'b0; fault <= 1'b1; busy <= 1'b0; sck_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_serial_port_chk.sv
module sync_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master,
  input logic       done,
  input logic       fault,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       sck_oe,
  input logic       pa_oe,
  input logic       pb_oe,
  input logic       sel_oe
);
  // R2
  role_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> (sck_oe && pa_oe && !pb_oe));
  // R2
  no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_oe |-> (!sck_oe && !pa_oe));
  // R8
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !master);
  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(bus_wr && bus_addr == 2'd1)) |=> fault);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(bus_rd && bus_addr == 2'd2)) |=> done);
  // R10
  gpio_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_oe |-> sck_oe);
endmodule

bind sync_serial_port sync_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .done(done), .fault(fault),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .sck_oe(sck_oe), .pa_oe(pa_oe), .pb_oe(pb_oe), .sel_oe(sel_oe)
);

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sck_in = 0, pa_in = 0, sel_n = 1;
  logic sck_o, sck_oe, pa_o, pa_oe, pb_o, pb_oe, sel_o, sel_oe;
  logic [7:0] slv_byte = 0, pb_sh = 0, cap_m = 0, cap_s = 0;
  logic m_load = 0, use_m = 0, oe_seen = 0;
  logic [7:0] d;
  int nchk = 0, nfail = 0;
  bit fin = 0;
  logic [7:0] exp_q[$];
  event frame_ev;

  always #5 clk = ~clk;

  sync_serial_port u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_i(sck_in), .sck_o(sck_o), .sck_oe(sck_oe), .pa_i(pa_in), .pa_o(pa_o),
    .pa_oe(pa_oe), .pb_i(pb_sh[7]), .pb_o(pb_o), .pb_oe(pb_oe),
    .sel_n_i(sel_n), .sel_o(sel_o), .sel_oe(sel_oe));

  always @(negedge sck_o or posedge m_load)
    if (m_load) pb_sh <= slv_byte; else pb_sh <= {pb_sh[6:0], 1'b0};
  always @(posedge sck_o) cap_m <= {cap_m[6:0], pa_o};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  initial forever begin
    @(frame_ev);
    if (exp_q.size() == 0) chk("R3/R6 scoreboard empty", 8'hxx, 8'h00);
    else chk("R3/R6 wire byte", use_m ? cap_m : cap_s, exp_q.pop_front());
  end

  task automatic mst_xfer(input logic [7:0] tx, input logic [7:0] rx, input int n);
    slv_byte = rx; m_load = 1; #1 m_load = 0;
    use_m = 1;
    exp_q.push_back(tx);
    wr(2'd0, {4'(n), 4'b0001});
    chk("R2 master enables", {5'd0, sck_oe, pa_oe, pb_oe}, 8'b110);
    wr(2'd2, tx);
    repeat (16*(n+1)-1) @(negedge clk);
    rd(2'd1, d); chk("R4 done not early", d & 8'h1, 8'h0);
    rd(2'd1, d); chk("R4/R5 done at 16(N+1)", d & 8'h1, 8'h1);
    chk("R4 sck idle low", {7'd0, sck_o}, 8'h0);
    ->frame_ev; #1;
    rd(2'd2, d); chk("R3 received byte", d, rx);
    rd(2'd1, d); chk("R5 done cleared by read", d & 8'h1, 8'h0);
  endtask

  task automatic slv_xfer(input logic [7:0] din, input bit selected);
    sel_n = !selected; oe_seen = 0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      pa_in = din[i];
      repeat (6) @(negedge clk);
      cap_s = {cap_s[6:0], pb_o};
      oe_seen = oe_seen | pb_oe;
      sck_in = 1;
      repeat (6) @(negedge clk);
      sck_in = 0;
    end
    repeat (8) @(negedge clk);
    sel_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 control reset", d, 8'h00);
    rd(2'd1, d); chk("R1 status reset", d, 8'h00);
    chk("R1 enables reset", {4'd0, sck_oe, pa_oe, pb_oe, sel_oe}, 8'h00);

    mst_xfer(8'hA5, 8'h3C, 3);
    mst_xfer(8'h81, 8'h7E, 0);

    wr(2'd0, 8'h00);
    chk("R2 slave clock/pin A released", {6'd0, sck_oe, pa_oe}, 8'h0);
    wr(2'd2, 8'h96);
    use_m = 0; exp_q.push_back(8'h96);
    slv_xfer(8'h4D, 1);
    chk("R6 pb_oe while selected", {7'd0, oe_seen}, 8'h1);
    ->frame_ev; #1;
    rd(2'd1, d); chk("R6 slave done", d & 8'h1, 8'h1);
    rd(2'd2, d); chk("R6 slave received", d, 8'h4D);

    wr(2'd2, 8'hF0);
    slv_xfer(8'h12, 0);
    chk("R7 pb_oe low unselected", {7'd0, oe_seen}, 8'h0);
    rd(2'd1, d); chk("R7 no done unselected", d & 8'h1, 8'h0);
    rd(2'd2, d); chk("R7 rx unchanged", d, 8'h4D);

    wr(2'd0, 8'h07);
    chk("R10 sel_oe/sel_o", {6'd0, sel_oe, sel_o}, 8'h3);
    sel_n = 0; repeat (5) @(negedge clk);
    rd(2'd1, d); chk("R10 no fault with reuse", d & 8'h2, 8'h0);
    rd(2'd0, d); chk("R10 still master", d & 8'h1, 8'h1);
    sel_n = 1; repeat (4) @(negedge clk);

    wr(2'd0, 8'h01);
    sel_n = 0; repeat (5) @(negedge clk);
    rd(2'd0, d); chk("R8 master bit cleared", d & 8'h1, 8'h0);
    rd(2'd1, d); chk("R8 fault set", d & 8'h2, 8'h2);
    chk("R8 outputs released", {6'd0, sck_oe, pa_oe}, 8'h0);
    sel_n = 1; repeat (6) @(negedge clk);
    rd(2'd1, d); chk("R9 fault sticky", d & 8'h2, 8'h2);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R9 fault cleared by write", d & 8'h2, 8'h0);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!fin) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule